// File: doc/BRIEF.md
# Write-Through Invalidate Snoop Cache Controller

This block is the private cache controller of one processor on a shared, single-master bus. It keeps a small direct-mapped array of one-word lines. Each line is either Valid or Invalid. Processor reads that hit a Valid line are answered locally in the same cycle. Read misses fetch the word over the bus and mark the line Valid. Every processor write goes to the bus. A write refreshes the local copy when the line is present and never allocates a line when it is absent.

The controller also watches a snoop port that shows every transaction on the bus, its own included. A write by another controller that matches a Valid local line drops that line to Invalid. Transactions carrying the controller's own requester ID are ignored. Since the bus orders all transactions, every controller sees the writes in the same sequence. That is enough to keep the write-through copies coherent.

The processor holds `cpu_req` and its operands steady until `cpu_ready` is high. A bus transaction takes place in any cycle in which `bus_req` and `bus_gnt` are both high. Read data on `bus_rdata` is valid in that same cycle.

Top module: `snp_wt_cache`

## Requirements
- R1: After a synchronous active-low reset every line is Invalid, so the first read of any address issues a bus read. During reset `cpu_ready` and `bus_req` are low.
- R2: A read miss raises `bus_req` with `bus_we` = 0 (0 = read, 1 = write) and `bus_addr` equal to the request address. `cpu_ready` is high in the grant cycle with `cpu_rdata` equal to `bus_rdata`, and the line is Valid from the next cycle.
- R3: A read that hits a Valid line raises `cpu_ready` in the cycle the request is presented, returns the stored word, and causes no bus transaction.
- R4: Every processor write, hit or miss, issues a bus write carrying the request address and data. `cpu_ready` is high only in the grant cycle.
- R5: A write to a Valid line updates the stored word at the grant, and a later read hit returns the new value.
- R6: A write to an absent line does not allocate: a later read of that address still misses.
- R7: A snooped write (`snp_valid` = 1, `snp_write` = 1) from a foreign ID whose address matches a Valid line makes that line Invalid.
- R8: Snooped transactions whose `snp_id` equals the parameter `MY_ID` change no line state.
- R9: When a foreign snooped write hits the same line as a read hit in the same cycle, the invalidation wins. `cpu_ready` stays low and the read is replayed as a bus read.
- R10: While waiting for a grant, `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` stay stable, and `cpu_ready` stays low.
- R11: Snooped reads, and snooped foreign writes whose address maps to the same line with a different tag (upper `ADDR_W - log2(LINES)` address bits; the index is the low bits), leave the line Valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_ready` on a read |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Grant; transfer happens when high with `bus_req` |
| bus_we | output | 1 | 1 = bus write, 0 = bus read |
| bus_addr | output | ADDR_W | Bus word address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_rdata | input | DATA_W | Bus read data, valid in the grant cycle |
| snp_valid | input | 1 | A bus transaction is visible on the snoop port |
| snp_write | input | 1 | The snooped transaction is a write |
| snp_id | input | ID_W | Requester ID of the snooped transaction |
| snp_addr | input | ADDR_W | Address of the snooped transaction |

## Verification
The embedded assertions check on every cycle that:
- reset empties the valid vector;
- a fill leaves the addressed line Valid with its tag;
- a foreign snoop hit clears its line one cycle later;
- a snoop carrying the own ID or a write miss never makes a line Valid or Invalid;
- bus outputs hold steady while the grant is pending;
- writes only complete with a granted bus write;
- a same-cycle snoop conflict blocks a read hit.

The returned data values, the choice between hit and miss across sequences of operations, and the non-allocating write only show up in the bench's scenarios. There, a scoreboard predicts each bus transfer and each read word from a reference memory.

// File: rtl/snp_pkg.sv
// Package: shared types of the write-through snoop cache controller.
// Assumes: nothing beyond SystemVerilog-2017.
package snp_pkg;
    typedef enum logic {
        CTL_IDLE = 1'b0,
        CTL_BUS  = 1'b1
    } ctl_state_e;
endpackage

// File: rtl/snp_snoop_filter.sv
// Module: snp_snoop_filter
// Turns a raw snoop observation into an invalidation request. Only foreign
// writes qualify; reads and the controller's own transactions are dropped.
// Assumes: the snoop port shows every bus transaction, including own ones.
module snp_snoop_filter #(
    parameter int ADDR_W = 10,
    parameter int LINES  = 16,
    parameter int ID_W   = 2,
    parameter int MY_ID  = 1,
    localparam int IDX_W = $clog2(LINES),
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              snp_valid,
    input  logic              snp_write,
    input  logic [ID_W-1:0]   snp_id,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              inv_en,
    output logic [IDX_W-1:0]  inv_idx,
    output logic [TAG_W-1:0]  inv_tag
);
    // Qualify the snoop and split its address into index and tag.
    always_comb begin
        inv_en  = snp_valid && snp_write && (snp_id != ID_W'(MY_ID));
        inv_idx = snp_addr[IDX_W-1:0];
        inv_tag = snp_addr[ADDR_W-1:IDX_W];
    end
endmodule

// File: rtl/snp_tag_store.sv
// Module: snp_tag_store
// Per-line valid bit and tag. It has one lookup port for the processor side,
// one snoop port that clears a matching Valid line, and a fill port.
// A snoop clear outranks a fill to the same line in the same cycle.
// Assumes: synchronous active-low reset; only valid bits are reset.
module snp_tag_store #(
    parameter int LINES  = 16,
    parameter int TAG_W  = 6,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              lk_hit,
    input  logic              sn_en,
    input  logic [IDX_W-1:0]  sn_idx,
    input  logic [TAG_W-1:0]  sn_tag,
    output logic              sn_hit,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [TAG_W-1:0]  fill_tag,
    output logic [LINES-1:0]  line_valid
);
    logic [LINES-1:0] vld_q;
    logic [TAG_W-1:0] tag_arr [LINES];

    genvar g;
    generate
        for (g = 0; g < LINES; g++) begin : g_line
            logic             v_q;
            logic [TAG_W-1:0] t_q;
            logic             clr_here;
            logic             set_here;

            // Decode whether this line is cleared or filled this cycle.
            always_comb begin
                clr_here = sn_hit && (sn_idx == IDX_W'(g));
                set_here = fill_en && (fill_idx == IDX_W'(g));
            end

            // Valid bit: reset to Invalid; a snoop clear wins over a fill.
            always_ff @(posedge clk) begin
                if (!rst_n)        v_q <= 1'b0;
                else if (clr_here) v_q <= 1'b0;
                else if (set_here) v_q <= 1'b1;
            end

            // Tag: written on every fill of this line.
            always_ff @(posedge clk) begin
                if (set_here) t_q <= fill_tag;
            end

            assign vld_q[g]   = v_q;
            assign tag_arr[g] = t_q;
        end
    endgenerate

    // Processor-side and snoop-side hit detection.
    always_comb begin
        lk_hit = vld_q[lk_idx] && (tag_arr[lk_idx] == lk_tag);
        sn_hit = sn_en && vld_q[sn_idx] && (tag_arr[sn_idx] == sn_tag);
    end

    assign line_valid = vld_q;

    // R1: reset leaves every line Invalid.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (vld_q == '0));

    // R7: a foreign snoop hit leaves its line Invalid next cycle.
    a_r7_snoop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        sn_hit |=> !vld_q[$past(sn_idx)]);

    // R2: a fill that no snoop overrides leaves the line Valid with its tag.
    a_r2_fill_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !(sn_hit && sn_idx == fill_idx))
        |=> (vld_q[$past(fill_idx)] && tag_arr[$past(fill_idx)] == $past(fill_tag)));
endmodule

// File: rtl/snp_data_store.sv
// Module: snp_data_store
// One data word per line. Combinational read, single synchronous write.
// Assumes: contents are meaningful only while the matching valid bit is set,
// so the array has no reset.
module snp_data_store #(
    parameter int LINES  = 16,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem_q [LINES];

    // Write port: store the word of a fill or of a write hit.
    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_idx] <= wr_data;
    end

    // Read port: the word of the looked-up line.
    assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/snp_ctl.sv
// Module: snp_ctl
// Request sequencer. In idle it answers read hits at once. Any other request
// is captured and held on the bus until the grant. At the grant it finishes
// the processor handshake, fills the line on a read, and refreshes the local
// word on a write hit.
// Assumes: the processor holds its request stable until cpu_ready; the bus
// completes a transfer in the grant cycle.
module snp_ctl
    import snp_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [ADDR_W-1:0] lk_addr,
    input  logic              lk_hit,
    input  logic              conflict,
    input  logic [DATA_W-1:0] cache_rdata,
    output logic              fill_en,
    output logic              dwr_en,
    output logic [DATA_W-1:0] dwr_data
);
    ctl_state_e        state_q;
    logic [ADDR_W-1:0] hold_addr_q;
    logic              hold_we_q;
    logic [DATA_W-1:0] hold_wdata_q;
    logic              local_ok;
    logic              serve_local;

    // Hit usable only if no snoop invalidates the same line this cycle.
    always_comb begin
        local_ok    = lk_hit && !conflict;
        serve_local = cpu_req && !cpu_we && local_ok;
    end

    // State and held request: capture on leaving idle, release on grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= CTL_IDLE;
            hold_addr_q  <= '0;
            hold_we_q    <= 1'b0;
            hold_wdata_q <= '0;
        end else begin
            unique case (state_q)
                CTL_IDLE: begin
                    if (cpu_req && !serve_local) begin
                        state_q      <= CTL_BUS;
                        hold_addr_q  <= cpu_addr;
                        hold_we_q    <= cpu_we;
                        hold_wdata_q <= cpu_wdata;
                    end
                end
                CTL_BUS: begin
                    if (bus_gnt) state_q <= CTL_IDLE;
                end
                default: state_q <= CTL_IDLE;
            endcase
        end
    end

    // Outputs: handshake, bus drive and cache update per state.
    always_comb begin
        bus_we    = hold_we_q;
        bus_addr  = hold_addr_q;
        bus_wdata = hold_wdata_q;
        bus_req   = 1'b0;
        cpu_ready = 1'b0;
        cpu_rdata = cache_rdata;
        lk_addr   = cpu_addr;
        fill_en   = 1'b0;
        dwr_en    = 1'b0;
        dwr_data  = hold_we_q ? hold_wdata_q : bus_rdata;
        unique case (state_q)
            CTL_IDLE: begin
                cpu_ready = serve_local;
            end
            CTL_BUS: begin
                lk_addr   = hold_addr_q;
                bus_req   = 1'b1;
                cpu_ready = bus_gnt;
                cpu_rdata = bus_rdata;
                fill_en   = bus_gnt && !hold_we_q;
                dwr_en    = bus_gnt && (!hold_we_q || local_ok);
            end
            default: ;
        endcase
    end

    // R4: a write can only complete through a granted bus write.
    a_r4_write_via_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_ready && cpu_we) |-> (bus_req && bus_gnt && bus_we));

    // R10: bus outputs hold steady until granted; processor stays stalled.
    a_r10_hold_until_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)
                                   && $stable(bus_wdata)));
    a_r10_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |-> !cpu_ready);

    // R3: a request served without the bus leaves the bus idle next cycle.
    a_r3_hit_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_ready && !bus_req) |=> !bus_req);
endmodule

// File: rtl/snp_wt_cache.sv
// Module: snp_wt_cache (top)
// Direct-mapped write-through cache controller with Valid/Invalid lines and
// write-invalidate snooping. Index = low address bits, tag = the rest.
// Assumes: single-master bus where a transfer completes in the grant cycle;
// the snoop port mirrors every bus transfer with its requester ID.
module snp_wt_cache #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32,
    parameter int LINES  = 16,
    parameter int ID_W   = 2,
    parameter int MY_ID  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              snp_valid,
    input  logic              snp_write,
    input  logic [ID_W-1:0]   snp_id,
    input  logic [ADDR_W-1:0] snp_addr
);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [ADDR_W-1:0] lk_addr;
    logic [IDX_W-1:0]  lk_idx;
    logic [TAG_W-1:0]  lk_tag;
    logic              lk_hit;
    logic              inv_en;
    logic [IDX_W-1:0]  inv_idx;
    logic [TAG_W-1:0]  inv_tag;
    logic              sn_hit;
    logic              conflict;
    logic              fill_en;
    logic              dwr_en;
    logic [DATA_W-1:0] dwr_data;
    logic [DATA_W-1:0] cache_rdata;
    logic [LINES-1:0]  line_valid;

    // Split the lookup address and flag a snoop clear on the looked-up line.
    always_comb begin
        lk_idx   = lk_addr[IDX_W-1:0];
        lk_tag   = lk_addr[ADDR_W-1:IDX_W];
        conflict = sn_hit && (inv_idx == lk_idx);
    end

    snp_snoop_filter #(
        .ADDR_W(ADDR_W), .LINES(LINES), .ID_W(ID_W), .MY_ID(MY_ID)
    ) u_filter (
        .snp_valid(snp_valid), .snp_write(snp_write), .snp_id(snp_id),
        .snp_addr(snp_addr), .inv_en(inv_en), .inv_idx(inv_idx), .inv_tag(inv_tag)
    );

    snp_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n),
        .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_hit(lk_hit),
        .sn_en(inv_en), .sn_idx(inv_idx), .sn_tag(inv_tag), .sn_hit(sn_hit),
        .fill_en(fill_en), .fill_idx(lk_idx), .fill_tag(lk_tag),
        .line_valid(line_valid)
    );

    snp_data_store #(.LINES(LINES), .DATA_W(DATA_W)) u_data (
        .clk(clk), .wr_en(dwr_en), .wr_idx(lk_idx), .wr_data(dwr_data),
        .rd_idx(lk_idx), .rd_data(cache_rdata)
    );

    snp_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .lk_addr(lk_addr), .lk_hit(lk_hit), .conflict(conflict),
        .cache_rdata(cache_rdata), .fill_en(fill_en), .dwr_en(dwr_en),
        .dwr_data(dwr_data)
    );

    // R8: own-ID snoops never change line state (barring a concurrent fill).
    a_r8_own_id_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_id == ID_W'(MY_ID) && !fill_en)
        |=> (line_valid == $past(line_valid)));

    // R9: a read hit clashing with a foreign invalidation is not answered.
    a_r9_snoop_beats_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_we && !bus_req && sn_hit && inv_idx == lk_idx)
        |-> !cpu_ready);

    // R6: a granted write that misses makes no line newly Valid.
    a_r6_no_write_alloc: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_gnt && bus_we && !lk_hit)
        |=> ((line_valid & ~$past(line_valid)) == '0));
endmodule

// File: tb/snp_wt_cache_bench.sv
`timescale 1ns/1ps
module snp_wt_cache_bench;
    localparam int AW   = 10;
    localparam int DW   = 32;
    localparam int IW   = 2;
    localparam int MYID = 1;
    localparam int FID  = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cpu_req, cpu_we;
    logic [AW-1:0] cpu_addr;
    logic [DW-1:0] cpu_wdata;
    logic          cpu_ready;
    logic [DW-1:0] cpu_rdata;
    logic          bus_req, bus_we;
    logic          bus_gnt = 1'b0;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata, bus_rdata;
    logic          snp_valid, snp_write;
    logic [IW-1:0] snp_id;
    logic [AW-1:0] snp_addr;
    logic          f_valid, f_write;
    logic [IW-1:0] f_id;
    logic [AW-1:0] f_addr;
    logic [DW-1:0] mem [1024];

    int n_chk  = 0;
    int n_fail = 0;
    int gnt_delay = 0;
    int gcnt = 0;
    bit finished = 0;
    string cur_tag = "R1";

    typedef struct { bit we; logic [AW-1:0] addr; logic [DW-1:0] data; string tag; } bus_item_t;
    typedef struct { logic [DW-1:0] data; string tag; } rd_item_t;
    bus_item_t bus_q[$];
    rd_item_t  rd_q[$];

    always #4 clk = ~clk;

    snp_wt_cache #(.ADDR_W(AW), .DATA_W(DW), .LINES(16), .ID_W(IW), .MY_ID(MYID)) u_snp_wt_cache (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .snp_valid(snp_valid), .snp_write(snp_write), .snp_id(snp_id), .snp_addr(snp_addr)
    );

    // Reference memory and snoop mirror of the shared bus.
    assign bus_rdata = mem[bus_addr];
    wire own_xfer = bus_req && bus_gnt;
    assign snp_valid = own_xfer | f_valid;
    assign snp_write = own_xfer ? bus_we : f_write;
    assign snp_id    = own_xfer ? IW'(MYID) : f_id;
    assign snp_addr  = own_xfer ? bus_addr : f_addr;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Arbiter model: grant after gnt_delay waiting cycles, for one cycle.
    always @(negedge clk) begin
        if (!rst_n) begin
            bus_gnt <= 1'b0;
            gcnt = 0;
        end else if (bus_req && !bus_gnt) begin
            if (gcnt >= gnt_delay) begin
                bus_gnt <= 1'b1;
                gcnt = 0;
            end else gcnt++;
        end else bus_gnt <= 1'b0;
    end

    // Monitor: pop and compare bus transfers and completed reads.
    always @(negedge clk) begin
        #2;
        if (rst_n && !finished) begin
            if (bus_req && bus_gnt) begin
                if (bus_q.size() == 0) begin
                    chk(0, cur_tag, "unexpected bus transfer addr", DW'(bus_addr), 0);
                end else begin
                    bus_item_t e;
                    e = bus_q.pop_front();
                    chk(bus_we == e.we, e.tag, "bus_we", DW'(bus_we), DW'(e.we));
                    chk(bus_addr == e.addr, e.tag, "bus_addr", DW'(bus_addr), DW'(e.addr));
                    if (e.we) chk(bus_wdata == e.data, e.tag, "bus_wdata", bus_wdata, e.data);
                end
                if (bus_we) mem[bus_addr] = bus_wdata;
            end
            if (cpu_req && cpu_ready && !cpu_we) begin
                if (rd_q.size() == 0) begin
                    chk(0, cur_tag, "unexpected read completion", cpu_rdata, 0);
                end else begin
                    rd_item_t r;
                    r = rd_q.pop_front();
                    chk(cpu_rdata == r.data, r.tag, "cpu_rdata", cpu_rdata, r.data);
                end
            end
        end
    end

    // Driver handshake: present a request, wait for ready, then release.
    task automatic run_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input string tag, input bit clash);
        int waited = 0;
        bit done = 0;
        cur_tag = tag;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        if (clash) begin
            f_valid = 1'b1; f_write = 1'b1; f_id = IW'(FID); f_addr = a;
        end
        while (!done) begin
            #3;
            if (clash && waited == 0)
                chk(!cpu_ready, "R9", "cpu_ready during snoop clash", DW'(cpu_ready), 0);
            if (bus_req) begin
                chk(bus_addr == a && bus_we == we, "R10", "held bus addr", DW'(bus_addr), DW'(a));
                if (!bus_gnt) chk(!cpu_ready, "R10", "ready while waiting", DW'(cpu_ready), 0);
            end
            if (cpu_ready) done = 1;
            else begin
                waited++;
                if (waited > 40) begin
                    chk(0, tag, "handshake timeout", 0, 1);
                    done = 1;
                end else begin
                    @(negedge clk);
                    f_valid = 1'b0;
                end
            end
        end
        @(negedge clk);
        cpu_req = 1'b0;
        f_valid = 1'b0;
    endtask

    task automatic drained(input string tag);
        chk(bus_q.size() == 0 && rd_q.size() == 0, tag, "scoreboard drained",
            DW'(bus_q.size() + rd_q.size()), 0);
    endtask

    task automatic do_read(input logic [AW-1:0] a, input bit miss, input string tag, input bit clash);
        rd_q.push_back('{mem[a], tag});
        if (miss) bus_q.push_back('{1'b0, a, '0, tag});
        run_op(1'b0, a, '0, tag, clash);
        drained(tag);
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
        bus_q.push_back('{1'b1, a, d, tag});
        run_op(1'b1, a, d, tag, 1'b0);
        drained(tag);
    endtask

    task automatic foreign(input bit wr, input int id, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        f_valid = 1'b1; f_write = wr; f_id = IW'(id); f_addr = a;
        if (wr && id != MYID) mem[a] = d;
        @(negedge clk);
        f_valid = 1'b0;
    endtask

    localparam logic [AW-1:0] A  = 10'h012;
    localparam logic [AW-1:0] A2 = 10'h022;
    localparam logic [AW-1:0] B  = 10'h0A3;
    localparam logic [AW-1:0] C  = 10'h155;

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 32'h5A000000 ^ (i * 32'h00010003);
        rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
        f_valid = 1'b0; f_write = 1'b0; f_id = '0; f_addr = '0;
        repeat (3) @(negedge clk);
        #2;
        chk(!cpu_ready, "R1", "cpu_ready in reset", DW'(cpu_ready), 0);
        chk(!bus_req, "R1", "bus_req in reset", DW'(bus_req), 0);
        @(negedge clk);
        rst_n = 1'b1;

        do_read(A, 1, "R1", 0);          // first read after reset misses
        do_read(B, 1, "R2", 0);          // miss fills
        do_read(A, 0, "R3", 0);          // hit, no bus
        do_read(B, 0, "R2", 0);          // filled line now hits
        do_write(A, 32'h11112222, "R4"); // write hit goes to bus
        do_read(A, 0, "R5", 0);          // local copy refreshed
        do_write(10'h0B4, 32'h33334444, "R6"); // write miss
        do_read(10'h0B4, 1, "R6", 0);    // not allocated
        foreign(1, FID, A, 32'hDEAD0001);
        do_read(A, 1, "R7", 0);          // invalidated by foreign write
        foreign(1, MYID, A, 32'h0);
        do_read(A, 0, "R8", 0);          // own id ignored
        foreign(0, FID, A, 32'h0);
        foreign(1, FID, A2, 32'hBEEF0002);
        do_read(A, 0, "R11", 0);         // snoop read / other tag ignored
        do_read(A2, 1, "R11", 0);        // A2 never cached
        do_read(A, 1, "R2", 0);          // A2 replaced A
        mem[A] = 32'hCAFE0009;
        do_read(A, 1, "R9", 1);          // clash replays as miss
        do_read(A, 0, "R9", 0);
        gnt_delay = 4;
        do_read(C, 1, "R10", 0);
        do_write(C, 32'h77778888, "R10");
        gnt_delay = 0;
        do_read(C, 0, "R5", 0);
        for (int i = 0; i < 16; i++) do_read(AW'(10'h300 + i), 1, "R2", 0);
        for (int i = 0; i < 16; i++) do_read(AW'(10'h300 + i), 0, "R3", 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not complete actual=0 expected=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule